// File: doc/BRIEF.md
# Single-Channel Bus-Master Byte Mover

This block moves a run of bytes between system memory and one IO device port so that the processor does not have to copy them itself. Software reaches it as a slave on the system bus through five 32-bit registers. It loads a start address and a byte count, then writes a command code. From that point the block works on its own as a bus master. For every byte it asks an external arbiter for the bus, makes one memory access at the current address, and passes the byte through its staging (data) register to or from the IO port. It then steps the address up and the count down, and repeats until the count is exhausted.

The memory-to-IO direction reads memory and offers the byte on an output valid/ready port. The IO-to-memory direction first accepts a byte on an input valid/ready port and then writes it to memory. The bus request is dropped after every byte, so other masters can win the bus between bytes. Software polls the status register; a value of zero means the engine is idle, or that the last transfer has finished.

Top module: `dma_engine`

## Requirements
- R1: After reset, status, data, address and count all read 0, and bus_req, mem_en, io_out_valid and io_in_ready are low.
- R2: The registers sit at byte addresses CSR_BASE+0 (status, read only), +4 (command), +8 (data, 8 bits), +12 (address) and +16 (count), with CSR_BASE = 2000. While idle, data, address and count read back what was written. A write lands on the clock edge where csr_sel and csr_wr are high. csr_rdata is combinational while csr_sel is high and csr_wr is low.
- R3: Command code 1 starts a memory-to-IO transfer when the count is nonzero. For each byte, the block reads memory at the current address, holds the byte in the data register, and offers it on io_out_data with io_out_valid.
- R4: Command code 2 starts an IO-to-memory transfer when the count is nonzero. For each byte, the block takes the byte offered on io_in_data during an io_in_valid/io_in_ready handshake, then writes it to memory at the current address (mem_we high). The last byte remains readable in the data register.
- R5: mem_en is raised only while bus_req is high and bus_gnt is granted. bus_req falls in the cycle after the memory access is acknowledged, so each byte moved produces exactly one rising edge of bus_req.
- R6: Each byte moved adds 1 to the address and subtracts 1 from the count. At the end, address = start + N and count = 0.
- R7: Status reads 0 when idle, 1 while a memory-to-IO transfer is busy, and 2 while an IO-to-memory transfer is busy. Status returns to 0 when the count reaches 0.
- R8: A start command with count 0 leaves the block idle: status stays 0 and no bus request is made.
- R9: A command value other than 1 or 2 has no effect. While the block is busy, all register writes are ignored, including a second command; the running transfer continues unchanged.
- R10: While io_out_valid is high and io_out_ready is low, io_out_valid stays high and io_out_data stays stable. The block waits for io_in_valid before it takes an input byte.
- R11: While mem_en is high and mem_ack is low, mem_en, mem_addr, mem_we and mem_wdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_sel | input | 1 | Register access strobe |
| csr_wr | input | 1 | Register access is a write |
| csr_addr | input | CSR_AW | Register byte address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access completes on this edge |
| io_out_valid | output | 1 | Byte offered to the IO device |
| io_out_ready | input | 1 | IO device accepts the offered byte |
| io_out_data | output | DATA_W | Byte to the IO device |
| io_in_valid | input | 1 | IO device offers a byte |
| io_in_ready | output | 1 | Block accepts the offered byte |
| io_in_data | input | DATA_W | Byte from the IO device |

## Verification
A register write takes effect on the edge that samples it. Status therefore shows busy in the first read after the command, and read data is combinational within the same cycle. All outputs are Moore outputs of the state register, so every handshake (grant, memory acknowledge, IO valid/ready) is judged one clock after the responder drives it. The responders change their inputs on falling edges and judge each transfer at the falling edge before the edge that completes it. The scoreboard pops an expected byte or write exactly when a handshake will complete, not after a fixed latency. End results (address, count, status, the number of bus request edges) are read through the register port only after polling shows status 0.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_IN_IO  = 3'd1,
        ST_ARB    = 3'd2,
        ST_MEM    = 3'd3,
        ST_OUT_IO = 3'd4
    } dma_state_e;

    localparam int unsigned NUM_REGS   = 5;
    localparam int unsigned REG_STRIDE = 4;

    localparam int unsigned IX_STATUS = 0;
    localparam int unsigned IX_CMD    = 1;
    localparam int unsigned IX_DATA   = 2;
    localparam int unsigned IX_ADDR   = 3;
    localparam int unsigned IX_COUNT  = 4;

    localparam logic [31:0] CMD_MEM_TO_IO = 32'd1;
    localparam logic [31:0] CMD_IO_TO_MEM = 32'd2;

    localparam logic [1:0] STAT_IDLE   = 2'd0;
    localparam logic [1:0] STAT_TO_IO  = 2'd1;
    localparam logic [1:0] STAT_TO_MEM = 2'd2;

    typedef struct packed {
        dma_state_e state;
        logic       to_mem;
    } fsm_state_s;

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
    import dma_pkg::*;
#(
    parameter int unsigned CSR_AW   = 16,
    parameter int unsigned CSR_BASE = 2000
) (
    input  logic [CSR_AW-1:0]   csr_addr,
    output logic [NUM_REGS-1:0] reg_hit
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        localparam int unsigned OFFSET = CSR_BASE + i * REG_STRIDE;
        assign reg_hit[i] = (csr_addr == CSR_AW'(OFFSET));
    end

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int unsigned MEM_AW = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] wr_sel,
    input  logic [DATA_W-1:0]   wr_data_byte,
    input  logic [MEM_AW-1:0]   wr_addr_val,
    input  logic [CNT_W-1:0]    wr_count_val,
    input  logic [NUM_REGS-1:0] rd_sel,
    input  logic [1:0]          status_code,
    input  logic                step,
    input  logic                cap_mem,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                cap_io,
    input  logic [DATA_W-1:0]   io_in_data,
    output logic [MEM_AW-1:0]   addr_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic [DATA_W-1:0]   data_q,
    output logic [31:0]         rdata
);

    typedef struct packed {
        logic [MEM_AW-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
    } regs_s;

    regs_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_sel[IX_DATA])  r_d.data = wr_data_byte;
        if (wr_sel[IX_ADDR])  r_d.addr = wr_addr_val;
        if (wr_sel[IX_COUNT]) r_d.cnt  = wr_count_val;
        if (cap_mem)          r_d.data = mem_rdata;
        if (cap_io)           r_d.data = io_in_data;
        if (step) begin
            r_d.addr = r_q.addr + MEM_AW'(1);
            r_d.cnt  = r_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_q = r_q.addr;
    assign cnt_q  = r_q.cnt;
    assign data_q = r_q.data;

    always_comb begin
        rdata = '0;
        if (rd_sel[IX_STATUS]) rdata = 32'(status_code);
        if (rd_sel[IX_DATA])   rdata = 32'(r_q.data);
        if (rd_sel[IX_ADDR])   rdata = 32'(r_q.addr);
        if (rd_sel[IX_COUNT])  rdata = 32'(r_q.cnt);
    end

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_to_io,
    input  logic       start_to_mem,
    input  logic       cnt_last,
    input  logic       bus_gnt,
    input  logic       mem_ack,
    input  logic       io_out_ready,
    input  logic       io_in_valid,
    output logic       busy,
    output logic [1:0] status_code,
    output logic       bus_req,
    output logic       mem_en,
    output logic       mem_we,
    output logic       io_out_valid,
    output logic       io_in_ready,
    output logic       step,
    output logic       cap_mem,
    output logic       cap_io
);

    fsm_state_s s_d, s_q;

    always_comb begin
        s_d          = s_q;
        bus_req      = 1'b0;
        mem_en       = 1'b0;
        mem_we       = 1'b0;
        io_out_valid = 1'b0;
        io_in_ready  = 1'b0;
        step         = 1'b0;
        cap_mem      = 1'b0;
        cap_io       = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_to_io) begin
                    s_d.state  = ST_ARB;
                    s_d.to_mem = 1'b0;
                end else if (start_to_mem) begin
                    s_d.state  = ST_IN_IO;
                    s_d.to_mem = 1'b1;
                end
            end
            ST_IN_IO: begin
                io_in_ready = 1'b1;
                if (io_in_valid) begin
                    cap_io    = 1'b1;
                    s_d.state = ST_ARB;
                end
            end
            ST_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) s_d.state = ST_MEM;
            end
            ST_MEM: begin
                bus_req = 1'b1;
                mem_en  = 1'b1;
                mem_we  = s_q.to_mem;
                if (mem_ack) begin
                    if (s_q.to_mem) begin
                        step      = 1'b1;
                        s_d.state = cnt_last ? ST_IDLE : ST_IN_IO;
                    end else begin
                        cap_mem   = 1'b1;
                        s_d.state = ST_OUT_IO;
                    end
                end
            end
            ST_OUT_IO: begin
                io_out_valid = 1'b1;
                if (io_out_ready) begin
                    step      = 1'b1;
                    s_d.state = cnt_last ? ST_IDLE : ST_ARB;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, to_mem: 1'b0};
        else        s_q <= s_d;
    end

    assign busy        = (s_q.state != ST_IDLE);
    assign status_code = !busy ? STAT_IDLE : (s_q.to_mem ? STAT_TO_MEM : STAT_TO_IO);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int unsigned CSR_AW   = 16,
    parameter int unsigned CSR_BASE = 2000,
    parameter int unsigned MEM_AW   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_sel,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              io_out_valid,
    input  logic              io_out_ready,
    output logic [DATA_W-1:0] io_out_data,
    input  logic              io_in_valid,
    output logic              io_in_ready,
    input  logic [DATA_W-1:0] io_in_data
);

    logic [NUM_REGS-1:0] reg_hit;
    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_REGS-1:0] rd_sel;
    logic                busy;
    logic [1:0]          status_code;
    logic                step, cap_mem, cap_io;
    logic [MEM_AW-1:0]   addr_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [DATA_W-1:0]   data_q;
    logic                cmd_wr;
    logic                start_to_io, start_to_mem;

    dma_addr_decode #(
        .CSR_AW   (CSR_AW),
        .CSR_BASE (CSR_BASE)
    ) u_dec (
        .csr_addr (csr_addr),
        .reg_hit  (reg_hit)
    );

    assign wr_sel = reg_hit & {NUM_REGS{csr_sel & csr_wr & ~busy}};
    assign rd_sel = reg_hit & {NUM_REGS{csr_sel & ~csr_wr}};

    assign cmd_wr       = wr_sel[IX_CMD] && (cnt_q != '0);
    assign start_to_io  = cmd_wr && (csr_wdata == CMD_MEM_TO_IO);
    assign start_to_mem = cmd_wr && (csr_wdata == CMD_IO_TO_MEM);

    dma_regs #(
        .MEM_AW (MEM_AW),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_sel       (wr_sel),
        .wr_data_byte (csr_wdata[DATA_W-1:0]),
        .wr_addr_val  (csr_wdata[MEM_AW-1:0]),
        .wr_count_val (csr_wdata[CNT_W-1:0]),
        .rd_sel       (rd_sel),
        .status_code  (status_code),
        .step         (step),
        .cap_mem      (cap_mem),
        .mem_rdata    (mem_rdata),
        .cap_io       (cap_io),
        .io_in_data   (io_in_data),
        .addr_q       (addr_q),
        .cnt_q        (cnt_q),
        .data_q       (data_q),
        .rdata        (csr_rdata)
    );

    dma_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_to_io  (start_to_io),
        .start_to_mem (start_to_mem),
        .cnt_last     (cnt_q == CNT_W'(1)),
        .bus_gnt      (bus_gnt),
        .mem_ack      (mem_ack),
        .io_out_ready (io_out_ready),
        .io_in_valid  (io_in_valid),
        .busy         (busy),
        .status_code  (status_code),
        .bus_req      (bus_req),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .io_out_valid (io_out_valid),
        .io_in_ready  (io_in_ready),
        .step         (step),
        .cap_mem      (cap_mem),
        .cap_io       (cap_io)
    );

    assign mem_addr    = addr_q;
    assign mem_wdata   = data_q;
    assign io_out_data = data_q;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int unsigned MEM_AW = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              step,
    input logic [MEM_AW-1:0] addr_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_en,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              io_out_valid,
    input logic              io_out_ready,
    input logic [DATA_W-1:0] io_out_data,
    input logic              io_in_ready
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !mem_en && !io_out_valid && !io_in_ready));

    p_access_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (bus_req && bus_gnt));

    p_release_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_ack) |=> !bus_req);

    p_step_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_q == $past(cnt_q) - CNT_W'(1)) && (addr_q == $past(addr_q) + MEM_AW'(1)));

    p_busy_count_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_out_valid && !io_out_ready) |=> (io_out_valid && $stable(io_out_data)));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ack) |=> (mem_en && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind dma_engine dma_engine_chk #(
    .MEM_AW (MEM_AW),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .step         (step),
    .addr_q       (addr_q),
    .cnt_q        (cnt_q),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .io_out_valid (io_out_valid),
    .io_out_ready (io_out_ready),
    .io_out_data  (io_out_data),
    .io_in_ready  (io_in_ready)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;

    localparam int BASE = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_sel = 1'b0, csr_wr = 1'b0;
    logic [15:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        bus_req, bus_gnt = 1'b0;
    logic        mem_en, mem_we, mem_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = '0;
    logic        io_out_valid, io_out_ready = 1'b0;
    logic [7:0]  io_out_data;
    logic        io_in_valid = 1'b0, io_in_ready;
    logic [7:0]  io_in_data = '0;

    always #2 clk = ~clk;

    dma_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .csr_sel(csr_sel), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .io_out_valid(io_out_valid), .io_out_ready(io_out_ready), .io_out_data(io_out_data),
        .io_in_valid(io_in_valid), .io_in_ready(io_in_ready), .io_in_data(io_in_data)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [7:0]  exp_io[$];
    logic [23:0] exp_mem[$];

    int mem_lat = 0, gnt_lat = 1, ready_mode = 0;
    int req_rises = 0, out_count = 0, wr_count = 0;
    int out_stalls = 0, out_bad = 0, mem_stalls = 0, mem_bad = 0;
    int in_avail = 0;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] * 8'd7 + 8'd3;
    endfunction

    function automatic logic [7:0] srcf(input int i);
        return 8'hA0 ^ 8'(i * 13);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 32'(cyc), 32'd150000);
            summary();
            $finish;
        end
    end

    // arbiter: grant after gnt_lat cycles, held while requested
    int  gw = 0;
    logic prev_req = 1'b0;
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_gnt = 1'b0;
            gw = 0;
        end else if (!bus_gnt) begin
            if (gw >= gnt_lat) bus_gnt = 1'b1;
            else gw++;
        end
        if (bus_req && !prev_req) req_rises++;
        prev_req = bus_req;
    end

    // memory responder and write scoreboard
    int          mw = 0;
    logic        p_men = 1'b0, p_mack = 1'b0;
    logic [15:0] p_maddr = '0;
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (p_men && !p_mack) begin
                mem_stalls++;
                if (mem_addr != p_maddr) mem_bad++;
            end
            if (mw >= mem_lat) begin
                mem_ack = 1'b1;
                mem_rdata = memf(mem_addr);
                if (mem_we) begin
                    wr_count++;
                    if (exp_mem.size() == 0)
                        chk(1'b0, "R4 unexpected memory write", {8'h0, mem_addr, mem_wdata}, 32'h0);
                    else begin
                        logic [23:0] e;
                        e = exp_mem.pop_front();
                        chk({mem_addr, mem_wdata} == e, "R4 memory write addr/data",
                            {8'h0, mem_addr, mem_wdata}, {8'h0, e});
                    end
                end
            end else begin
                mem_ack = 1'b0;
                mw++;
            end
        end else begin
            mem_ack = 1'b0;
            mw = 0;
        end
        p_men = mem_en;
        p_mack = mem_ack;
        p_maddr = mem_addr;
    end

    // IO sink and output scoreboard
    int          sk = 0;
    logic        p_val = 1'b0, p_rdy = 1'b0;
    logic [7:0]  p_dat = '0;
    always @(negedge clk) begin
        sk++;
        if (p_val && !p_rdy) begin
            out_stalls++;
            if (!io_out_valid || io_out_data != p_dat) out_bad++;
        end
        io_out_ready = (ready_mode == 0) ? 1'b1 : ((sk % 4) == 0);
        if (io_out_valid && io_out_ready) begin
            out_count++;
            if (exp_io.size() == 0)
                chk(1'b0, "R3 unexpected output byte", 32'(io_out_data), 32'h0);
            else begin
                logic [7:0] e;
                e = exp_io.pop_front();
                chk(io_out_data == e, "R3 output byte", 32'(io_out_data), 32'(e));
            end
        end
        p_val = io_out_valid;
        p_rdy = io_out_ready;
        p_dat = io_out_data;
    end

    // IO source with gaps
    int src_idx = 0, sc = 0;
    bit take = 1'b0;
    always @(negedge clk) begin
        sc++;
        if (take) begin
            src_idx++;
            take = 1'b0;
        end
        io_in_valid = (src_idx < in_avail) && ((sc % 3) != 0);
        io_in_data  = srcf(src_idx);
        if (io_in_valid && io_in_ready) take = 1'b1;
    end

    task automatic wr(input int off, input logic [31:0] v);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b1;
        csr_addr = 16'(BASE + off); csr_wdata = v;
        @(negedge clk);
        csr_sel = 1'b0; csr_wr = 1'b0;
    endtask

    task automatic rd(input int off, output logic [31:0] v);
        @(negedge clk);
        csr_sel = 1'b1; csr_wr = 1'b0; csr_addr = 16'(BASE + off);
        #1 v = csr_rdata;
        csr_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 3000; k++) begin
            rd(0, s);
            if (s == 0) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v);  chk(v == 0, "R1 status after reset", v, 0);
        rd(8, v);  chk(v == 0, "R1 data after reset", v, 0);
        rd(12, v); chk(v == 0, "R1 address after reset", v, 0);
        rd(16, v); chk(v == 0, "R1 count after reset", v, 0);
        chk(!bus_req && !io_out_valid && !io_in_ready && !mem_en, "R1 outputs idle",
            {bus_req, io_out_valid, io_in_ready, mem_en}, 0);

        // R2 register map read-back
        wr(12, 32'h0010); wr(16, 32'd5); wr(8, 32'h5A);
        rd(12, v); chk(v == 32'h10, "R2 address read-back", v, 32'h10);
        rd(16, v); chk(v == 5, "R2 count read-back", v, 5);
        rd(8, v);  chk(v == 32'h5A, "R2 data read-back", v, 32'h5A);

        // R3 memory to IO with output stalls (R10) and busy writes (R9)
        ready_mode = 1;
        for (int i = 0; i < 5; i++) exp_io.push_back(memf(16'(16'h10 + i)));
        req_rises = 0; out_count = 0;
        wr(4, 32'd1);
        rd(0, v); chk(v == 1, "R7 status busy memory-to-IO", v, 1);
        wr(12, 32'h0300); wr(16, 32'd99); wr(4, 32'd2); wr(8, 32'hEE);
        wait_idle();
        chk(exp_io.size() == 0 && out_count == 5, "R3 all bytes delivered", 32'(out_count), 5);
        chk(req_rises == 5, "R5 one bus request per byte", 32'(req_rises), 5);
        rd(12, v); chk(v == 32'h15, "R6 final address", v, 32'h15);
        rd(16, v); chk(v == 0, "R6 final count", v, 0);
        rd(0, v);  chk(v == 0, "R7 status idle after done", v, 0);
        rd(8, v);  chk(v == 32'(memf(16'h14)), "R9 data not overwritten while busy", v, 32'(memf(16'h14)));
        chk(out_stalls > 0 && out_bad == 0, "R10 output held while stalled", 32'(out_bad), 0);

        // R4 IO to memory with input gaps
        ready_mode = 0;
        wr(12, 32'h0040); wr(16, 32'd4);
        base = in_avail;
        for (int i = 0; i < 4; i++) exp_mem.push_back({16'(16'h40 + i), srcf(base + i)});
        wr_count = 0; req_rises = 0;
        in_avail = base + 4;
        wr(4, 32'd2);
        rd(0, v); chk(v == 2, "R7 status busy IO-to-memory", v, 2);
        wait_idle();
        chk(exp_mem.size() == 0 && wr_count == 4, "R4 all bytes written", 32'(wr_count), 4);
        chk(req_rises == 4, "R5 one bus request per written byte", 32'(req_rises), 4);
        rd(12, v); chk(v == 32'h44, "R6 address after IO-to-memory", v, 32'h44);
        rd(16, v); chk(v == 0, "R6 count after IO-to-memory", v, 0);
        rd(8, v);  chk(v == 32'(srcf(base + 3)), "R4 last byte in data register", v, 32'(srcf(base + 3)));

        // R8 zero count start
        wr(16, 32'd0);
        req_rises = 0; out_count = 0;
        wr(4, 32'd1);
        rd(0, v); chk(v == 0, "R8 zero count stays idle", v, 0);
        repeat (10) @(negedge clk);
        chk(req_rises == 0 && out_count == 0, "R8 no bus request on zero count", 32'(req_rises), 0);

        // R9 invalid command code
        wr(12, 32'h0080); wr(16, 32'd3);
        wr(4, 32'd3);
        rd(0, v); chk(v == 0, "R9 invalid command leaves idle", v, 0);
        repeat (8) @(negedge clk);
        chk(req_rises == 0, "R9 invalid command no bus request", 32'(req_rises), 0);
        rd(12, v); chk(v == 32'h80, "R9 address unchanged", v, 32'h80);
        rd(16, v); chk(v == 3, "R9 count unchanged", v, 3);

        // R11 memory acknowledge stall
        mem_lat = 3; gnt_lat = 2; mem_stalls = 0; mem_bad = 0;
        for (int i = 0; i < 3; i++) exp_io.push_back(memf(16'(16'h80 + i)));
        out_count = 0;
        wr(4, 32'd1);
        wait_idle();
        chk(exp_io.size() == 0 && out_count == 3, "R11 bytes delivered with slow memory", 32'(out_count), 3);
        chk(mem_stalls > 0 && mem_bad == 0, "R11 access held until acknowledge", 32'(mem_bad), 0);
        rd(12, v); chk(v == 32'h83, "R6 address after slow memory run", v, 32'h83);

        summary();
        $finish;
    end

endmodule